// File: doc/BRIEF.md
# Byte-Lane Load/Store Aligner

This block sits between a 32-bit datapath and a memory port that is one word wide. Memory is addressed by byte. For each request it turns the byte address into a word address and, for a store, lays the data out in the correct byte lanes. It also produces a 4-bit lane write mask that covers only the bytes of the item being stored. A load returns the full memory word one cycle later. The block then picks the addressed byte, halfword or word out of that word and sign- or zero-extends it to 32 bits.

The parameter `BIG_ENDIAN` sets the byte numbering. When it is 0, byte offset 0 of a word is bits 7:0. When it is 1, byte offset 0 is bits 31:24. An access is aligned only when its address is a multiple of its size. A misaligned access never reaches memory, and the block raises `fault` for one cycle.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` always equals `req_addr[31:2]`.
- R2: For an aligned byte store (`req_size`=00) at offset o, `mem_be` has exactly one bit set: bit o when little-endian, bit 3-o when big-endian.
- R3: For an aligned halfword store (`req_size`=01, offset 0 or 2), `mem_be` has two bits set. Little-endian gives 0011 for offset 0 and 1100 for offset 2. Big-endian gives 1100 for offset 0 and 0011 for offset 2.
- R4: An aligned word store (`req_size`=10, offset 0) gives `mem_be`=1111.
- R5: `mem_wdata` carries the store data replicated across the lanes: a byte store gives four copies of `req_wdata[7:0]`, a halfword store gives two copies of `req_wdata[15:0]`, and a word store gives `req_wdata` unchanged.
- R6: A request is misaligned in three cases: a halfword with address bit 0 set, a word with either of address bits 1:0 set, or the reserved size 11. A misaligned request holds `mem_be` at 0 and `mem_req` low. In the next cycle `fault` is 1. `fault` is 0 in any cycle whose previous cycle had no misaligned request.
- R7: In the cycle after an aligned byte load, `ld_data` holds the addressed byte of `mem_rdata`. The lane used follows the same mapping as R2. When `req_unsigned`=0 the byte is sign-extended; when it is 1 the byte is zero-extended.
- R8: In the cycle after an aligned halfword load, `ld_data` holds the halfword, extended the same way as in R7. The byte at the lower address is the most significant byte when big-endian and the least significant byte when little-endian.
- R9: In the cycle after an aligned word load, `ld_data` equals `mem_rdata`.
- R10: Only an aligned load request updates the offset, size and signedness used for `ld_data`. Stores, misaligned requests and idle cycles leave them unchanged, and `ld_data` keeps following `mem_rdata` through the last aligned load's settings.
- R11: When there is no store request, `mem_be` is 0. `mem_req` is high exactly for aligned requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| req_unsigned | input | 1 | Zero-extend sub-word loads |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store data, right-justified |
| mem_req | output | 1 | Aligned request forwarded to memory |
| mem_addr | output | 30 | Word address |
| mem_be | output | 4 | Lane write mask |
| mem_wdata | output | 32 | Lane-replicated store data |
| mem_rdata | input | 32 | Word returned the cycle after a load |
| ld_data | output | 32 | Extracted and extended load result |
| fault | output | 1 | Alignment fault, one cycle after the request |

## Verification
Two instances, one per byte order, receive identical stimulus. Any lane-mapping error therefore shows up as a difference between the two orders rather than cancelling out. Stores are driven at every offset and size with distinct byte values, so a swapped lane or a missing replica is visible. Loads use a word whose bytes have the sign bit set and a word whose bytes have it clear, which separates sign extension from zero extension. Misaligned offsets, the reserved size, and stores placed after a load check fault timing, write suppression and that the captured load settings are retained.

// File: rtl/lsu_lane_align.sv
module lsu_lane_align #(
  parameter bit BIG_ENDIAN = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [1:0]  req_size,
  input  logic        req_unsigned,
  input  logic [31:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        mem_req,
  output logic [29:0] mem_addr,
  output logic [3:0]  mem_be,
  output logic [31:0] mem_wdata,
  input  logic [31:0] mem_rdata,
  output logic [31:0] ld_data,
  output logic        fault
);
  logic [1:0] off, blane, hlane;
  logic       misal, ok;
  logic [1:0] ld_off, ld_size;
  logic       ld_uns;
  logic [1:0] lbl, lhl;
  logic [7:0] lbyte;
  logic [15:0] lhalf;

  assign off   = req_addr[1:0];
  assign misal = (req_size == 2'b11) ||
                 (req_size == 2'b01 && off[0]) ||
                 (req_size == 2'b10 && off != 2'b00);
  assign ok    = req_valid && !misal;
  assign blane = BIG_ENDIAN ? ~off : off;
  assign hlane = BIG_ENDIAN ? {~off[1], 1'b0} : {off[1], 1'b0};

  assign mem_req  = ok;
  assign mem_addr = req_addr[31:2];

  always_comb begin
    mem_be = 4'b0000;
    if (ok && req_store) begin
      case (req_size)
        2'b00:   mem_be = 4'b0001 << blane;
        2'b01:   mem_be = 4'b0011 << hlane;
        default: mem_be = 4'b1111;
      endcase
    end
  end

  always_comb begin
    case (req_size)
      2'b00:   mem_wdata = {4{req_wdata[7:0]}};
      2'b01:   mem_wdata = {2{req_wdata[15:0]}};
      default: mem_wdata = req_wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault   <= 1'b0;
      ld_off  <= 2'b00;
      ld_size <= 2'b10;
      ld_uns  <= 1'b0;
    end else begin
      fault <= req_valid && misal;
      if (ok && !req_store) begin
        ld_off  <= off;
        ld_size <= req_size;
        ld_uns  <= req_unsigned;
      end
    end
  end

  assign lbl   = BIG_ENDIAN ? ~ld_off : ld_off;
  assign lhl   = BIG_ENDIAN ? {~ld_off[1], 1'b0} : {ld_off[1], 1'b0};
  assign lbyte = mem_rdata[8*lbl +: 8];
  assign lhalf = mem_rdata[8*lhl +: 16];

  always_comb begin
    case (ld_size)
      2'b00:   ld_data = {{24{lbyte[7] & ~ld_uns}}, lbyte};
      2'b01:   ld_data = {{16{lhalf[15] & ~ld_uns}}, lhalf};
      default: ld_data = mem_rdata;
    endcase
  end
endmodule

module lsu_lane_align_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic [31:0] req_addr,
  input logic [31:0] req_wdata,
  input logic        mem_req,
  input logic [29:0] mem_addr,
  input logic [3:0]  mem_be,
  input logic [31:0] mem_wdata,
  input logic [31:0] mem_rdata,
  input logic [31:0] ld_data,
  input logic        fault
);
  logic bad;
  assign bad = req_valid && ((req_size == 2'b11) ||
               (req_size == 2'b01 && req_addr[0]) ||
               (req_size == 2'b10 && req_addr[1:0] != 2'b00));

  p_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_addr == req_addr[31:2]);
  p_byte_be_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && req_size == 2'b00) |-> $countones(mem_be) == 1);
  p_half_be_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !bad && req_size == 2'b01) |-> $countones(mem_be) == 2);
  p_word_be_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_store && !bad && req_size == 2'b10) |-> mem_be == 4'hf);
  p_repl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_size == 2'b00) |-> (mem_wdata[31:24] == req_wdata[7:0] && mem_wdata[7:0] == req_wdata[7:0]));
  p_fault_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> fault);
  p_fault_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !fault);
  p_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> (mem_be == 4'h0 && !mem_req));
  p_word_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_store && !bad && req_size == 2'b10) |=> ld_data == mem_rdata);
  p_idle_be_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_store) |-> mem_be == 4'h0);
endmodule

bind lsu_lane_align lsu_lane_align_chk chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
  .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_be(mem_be),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .ld_data(ld_data), .fault(fault)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_store = 1'b0, req_unsigned = 1'b0;
  logic [1:0] req_size = 2'b00;
  logic [31:0] req_addr = '0, req_wdata = '0, mem_rdata = '0;
  logic mem_req [2];
  logic [29:0] mem_addr [2];
  logic [3:0] mem_be [2];
  logic [31:0] mem_wdata [2], ld_data [2];
  logic fault [2];

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit m_have = 0;
  logic [1:0] m_off = 0, m_size = 0;
  bit m_uns = 0;

  always #10 clk = ~clk;

  lsu_lane_align #(.BIG_ENDIAN(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_req(mem_req[0]), .mem_addr(mem_addr[0]),
    .mem_be(mem_be[0]), .mem_wdata(mem_wdata[0]), .mem_rdata(mem_rdata),
    .ld_data(ld_data[0]), .fault(fault[0]));

  lsu_lane_align #(.BIG_ENDIAN(1'b1)) dut_big_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_store(req_store),
    .req_size(req_size), .req_unsigned(req_unsigned), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_req(mem_req[1]), .mem_addr(mem_addr[1]),
    .mem_be(mem_be[1]), .mem_wdata(mem_wdata[1]), .mem_rdata(mem_rdata),
    .ld_data(ld_data[1]), .fault(fault[1]));

  task automatic chk(string req, int e, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s (%s-endian) got %h expected %h", req, e ? "big" : "little", got, exp);
    end
  endtask

  function automatic int lane(int big, int o);
    return big ? 3 - o : o;
  endfunction

  function automatic bit is_bad(logic [1:0] sz, logic [1:0] o);
    if (sz == 2'b11) return 1;
    if (sz == 2'b01) return o[0];
    if (sz == 2'b10) return o != 0;
    return 0;
  endfunction

  function automatic logic [3:0] ref_be(int big, logic [1:0] sz, logic [1:0] o);
    logic [3:0] be = 0;
    for (int i = 0; i < (1 << sz); i++) be[lane(big, o + i)] = 1'b1;
    return be;
  endfunction

  function automatic logic [31:0] ref_load(int big, logic [31:0] w, logic [1:0] sz,
                                           logic [1:0] o, bit uns);
    logic [7:0] b [4];
    logic [31:0] v;
    for (int i = 0; i < 4; i++) b[i] = w[8*lane(big, i) +: 8];
    if (sz == 2'b00) v = uns ? {24'h0, b[o]} : {{24{b[o][7]}}, b[o]};
    else if (sz == 2'b01) begin
      logic [15:0] h = big ? {b[o], b[o+1]} : {b[o+1], b[o]};
      v = uns ? {16'h0, h} : {{16{h[15]}}, h};
    end else v = big ? {b[0], b[1], b[2], b[3]} : {b[3], b[2], b[1], b[0]};
    return v;
  endfunction

  task automatic op(bit st, logic [1:0] sz, bit uns, logic [31:0] a,
                    logic [31:0] wd, logic [31:0] rd, string tag);
    bit bad = is_bad(sz, a[1:0]);
    @(negedge clk);
    req_valid = 1; req_store = st; req_size = sz; req_unsigned = uns;
    req_addr = a; req_wdata = wd;
    #2;
    for (int e = 0; e < 2; e++) begin
      chk("R1", e, {2'b0, mem_addr[e]}, {2'b0, a[31:2]});
      chk(bad ? "R6" : "R11", e, {31'b0, mem_req[e]}, {31'b0, !bad});
      if (st) begin
        chk(bad ? "R6" : tag, e, {28'b0, mem_be[e]}, bad ? 32'h0 : {28'b0, ref_be(e, sz, a[1:0])});
        if (!bad)
          chk("R5", e, mem_wdata[e], sz == 0 ? {4{wd[7:0]}} : sz == 1 ? {2{wd[15:0]}} : wd);
      end else
        chk("R11", e, {28'b0, mem_be[e]}, 32'h0);
    end
    if (!st && !bad) begin
      m_have = 1; m_off = a[1:0]; m_size = sz; m_uns = uns;
    end
    @(posedge clk);
    #1;
    req_valid = 0;
    mem_rdata = rd;
    #1;
    for (int e = 0; e < 2; e++) begin
      chk("R6", e, {31'b0, fault[e]}, {31'b0, bad});
      if (m_have)
        chk((!st && !bad) ? tag : "R10", e, ld_data[e], ref_load(e, rd, m_size, m_off, m_uns));
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    for (int e = 0; e < 2; e++) begin
      chk("R6", e, {31'b0, fault[e]}, 32'h0);
      chk("R11", e, {28'b0, mem_be[e]}, 32'h0);
    end
    @(negedge clk);
    rst_n = 1;
    for (int o = 0; o < 4; o++)
      op(1, 2'b00, 0, 32'h0000_1000 + o, 32'h0000_00A0 + o, 32'h0, "R2");
    op(1, 2'b01, 0, 32'h0000_2000, 32'h0000_BEEF, 32'h0, "R3");
    op(1, 2'b01, 0, 32'h0000_2002, 32'h0000_1234, 32'h0, "R3");
    op(1, 2'b10, 0, 32'hFFFF_FFFC, 32'hCAFE_F00D, 32'h0, "R4");
    op(1, 2'b01, 0, 32'h0000_2001, 32'h0000_5555, 32'h0, "R6");
    op(1, 2'b10, 0, 32'h0000_2002, 32'h0000_5555, 32'h0, "R6");
    op(1, 2'b11, 0, 32'h0000_2000, 32'h0000_5555, 32'h0, "R6");
    for (int o = 0; o < 4; o++) begin
      op(0, 2'b00, 0, 32'h0000_3000 + o, 0, 32'h8192_A3B4, "R7");
      op(0, 2'b00, 1, 32'h0000_3000 + o, 0, 32'h8192_A3B4, "R7");
      op(0, 2'b00, 0, 32'h0000_3000 + o, 0, 32'h1122_3344, "R7");
    end
    for (int o = 0; o < 4; o += 2) begin
      op(0, 2'b01, 0, 32'h0000_4000 + o, 0, 32'h8001_F07E, "R8");
      op(0, 2'b01, 1, 32'h0000_4000 + o, 0, 32'h8001_F07E, "R8");
      op(0, 2'b01, 0, 32'h0000_4000 + o, 0, 32'h1234_5678, "R8");
    end
    op(0, 2'b10, 0, 32'h0000_5000, 0, 32'hDEAD_BEEF, "R9");
    op(0, 2'b00, 0, 32'h0000_6001, 0, 32'h80FF_7F01, "R7");
    op(1, 2'b10, 0, 32'h0000_6000, 32'h1, 32'hF0E1_D2C3, "R10");
    op(0, 2'b01, 1, 32'h0000_6003, 0, 32'hAA55_CC33, "R10");
    op(1, 2'b00, 0, 32'h0000_6002, 32'h7, 32'h0102_0304, "R10");
    @(negedge clk);
    #1;
    for (int e = 0; e < 2; e++) chk("R6", e, {31'b0, fault[e]}, 32'h0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule